// File: doc/BRIEF.md
# Slave Sync Field and Line-Standard Tracker

This block serves a composite video encoder that runs as a timing slave. Another device drives active-low horizontal and vertical sync. The block samples both on the 27 MHz pixel clock and keeps a horizontal counter and a vertical counter aligned to them. Every vertical sync falling edge is placed against the current line. An edge near the start of a line opens field 1. An edge near the middle of a line opens field 2. An edge that lands exactly on a window boundary is discarded and flagged.

The block measures the length of each line and derives its field windows from that length. It counts lines per field to decide whether the source is a 525-line or a 625-line signal. The standard flag changes only after two full frames, which is four fields, agree. A lock flag shows that consecutive lines have the same length. The encoder's timing generator and pixel path read these outputs in place of configuration pins.

Top module: `sync_slave_tracker`

## Requirements
- R1: While `rst` is high, and after it, until the syncs act: `hcount`, `vcount`, `field2`, `std_625`, `locked` and `vs_misplaced` are all 0.
- R2: If `hsync_n` is first sampled low at clock edge k, `hcount` is 1 after edge k+1. Otherwise `hcount` grows by one per clock and saturates at all ones.
- R3: `vcount` grows by one, with the same latency as the `hcount` restart, at every `hsync_n` falling edge. A field-1 edge overrides this as R4 states.
- R4: Let L be the measured line length and o the value of `hcount` when the `vsync_n` fall is detected, taken modulo L. If o < L/4 or o > L - L/4, the edge starts field 1 and `field2` becomes 0. If o < L/4, `vcount` becomes 1 at once. Otherwise `vcount` becomes 1 at the next `hsync_n` fall.
- R5: If L/2 - L/4 < o < L/2 + L/4, the edge starts field 2: `field2` becomes 1 and `vcount` keeps counting.
- R6: An edge inside neither window (o equal to L/4 or to L - L/4) does not change `field2` or `vcount`. It raises `vs_misplaced` for exactly one clock.
- R7: Until one full line has been measured, which takes two `hsync_n` falls, `vsync_n` falls are ignored and raise no flag.
- R8: At each `hsync_n` fall from the third onward, `locked` becomes 1 if the line just ended has the same length as the line before it, and 0 if not.
- R9: At each accepted field edge after the first, the lines counted since the previous accepted edge are classified. 262 or 263 lines means 525, 312 or 313 means 625, and any other count means neither. `std_625` (1 = 625 lines) changes only when four consecutive classifications agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | External horizontal sync, active low |
| vsync_n | input | 1 | External vertical sync, active low |
| hcount | output | HCNT_W | Horizontal position, 1 at line start |
| vcount | output | VCNT_W | Line number, 1 at field-1 start |
| field2 | output | 1 | 0 in field 1, 1 in field 2 |
| std_625 | output | 1 | Detected standard: 0 = 525 lines, 1 = 625 lines |
| locked | output | 1 | Last two line lengths were equal |
| vs_misplaced | output | 1 | One-clock pulse for a discarded vertical edge |

## Verification
The assertions check on every cycle that each counter or flag changes only for its own cause. `hcount` returns to 1 exactly two edges after an HSYNC fall and otherwise steps by one. `vcount`, `field2`, `locked` and `std_625` move only a fixed number of cycles after a sync fall, and the misplacement flag lasts one cycle. Only the bench scenarios can show where the field windows lie. It sweeps the vertical edge across every position of a short line and checks each result. The bench also shows that the standard flag needs four agreeing fields, and that lock drops and returns after an irregular line.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_525  = 2'd1,
    CLS_625  = 2'd2
  } line_std_e;
endpackage

// File: rtl/sst_sync_sampler.sv
// Samples one active-low sync input and flags its falling edge.
module sst_sync_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  output logic fall
);
  logic now_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      now_q  <= sync_n;
      prev_q <= now_q;
    end
  end

  assign fall = prev_q & ~now_q;
endmodule

// File: rtl/sst_line_timer.sv
// Horizontal counter, line length measurement and lock.
module sst_line_timer #(
  parameter int HCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_fall,
  output logic [HCNT_W-1:0] hcount,
  output logic [HCNT_W-1:0] line_len,
  output logic              line_ok,
  output logic              locked
);
  logic started;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount   <= '0;
      line_len <= '0;
      line_ok  <= 1'b0;
      locked   <= 1'b0;
      started  <= 1'b0;
    end else if (hs_fall) begin
      hcount  <= HCNT_W'(1);
      started <= 1'b1;
      if (started) begin
        line_len <= hcount;
        line_ok  <= 1'b1;
        if (line_ok) begin
          locked <= (hcount == line_len);
        end
      end
    end else if (hcount != '1) begin
      hcount <= hcount + 1'b1;
    end
  end
endmodule

// File: rtl/sst_field_tracker.sv
// Places vertical edges in the line, keeps the vertical counter and
// reports the lines seen in each field.
module sst_field_tracker #(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_fall,
  input  logic              vs_fall,
  input  logic [HCNT_W-1:0] hcount,
  input  logic [HCNT_W-1:0] line_len,
  input  logic              line_ok,
  output logic [VCNT_W-1:0] vcount,
  output logic              field2,
  output logic              misplaced,
  output logic              fld_mark,
  output logic [VCNT_W-1:0] fld_lines
);
  logic [HCNT_W-1:0] offset;
  logic [HCNT_W-1:0] quarter;
  logic [HCNT_W-1:0] half;
  logic              in_start;
  logic              in_early;
  logic              in_mid;
  logic              vpend;
  logic [VCNT_W-1:0] line_cnt;

  always_comb begin
    quarter  = line_len >> 2;
    half     = line_len >> 1;
    offset   = (hcount >= line_len) ? (hcount - line_len) : hcount;
    in_early = (offset < quarter);
    in_start = in_early || (offset > (line_len - quarter));
    in_mid   = (offset > (half - quarter)) && (offset < (half + quarter));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcount    <= '0;
      vpend     <= 1'b0;
      field2    <= 1'b0;
      misplaced <= 1'b0;
      fld_mark  <= 1'b0;
      fld_lines <= '0;
      line_cnt  <= '0;
    end else begin
      misplaced <= 1'b0;
      fld_mark  <= 1'b0;
      if (hs_fall) begin
        if (line_cnt != '1) line_cnt <= line_cnt + 1'b1;
        if (vpend) begin
          vcount <= VCNT_W'(1);
          vpend  <= 1'b0;
        end else if (vcount != '1) begin
          vcount <= vcount + 1'b1;
        end
      end
      if (vs_fall && line_ok) begin
        if (in_start) begin
          field2    <= 1'b0;
          fld_mark  <= 1'b1;
          fld_lines <= line_cnt;
          line_cnt  <= '0;
          if (in_early) begin
            vcount <= VCNT_W'(1);
            vpend  <= 1'b0;
          end else begin
            vpend  <= 1'b1;
          end
        end else if (in_mid) begin
          field2    <= 1'b1;
          fld_mark  <= 1'b1;
          fld_lines <= line_cnt;
          line_cnt  <= '0;
        end else begin
          misplaced <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sst_std_detector.sv
// Classifies field lengths and switches the standard after agreement.
module sst_std_detector
  import sst_pkg::*;
#(
  parameter int VCNT_W       = 10,
  parameter int AGREE_FIELDS = 4,
  parameter int F525_MIN     = 262,
  parameter int F525_MAX     = 263,
  parameter int F625_MIN     = 312,
  parameter int F625_MAX     = 313
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fld_mark,
  input  logic [VCNT_W-1:0] fld_lines,
  output logic              std_625
);
  localparam int SW = $clog2(AGREE_FIELDS + 1);
  localparam logic [SW-1:0]     AGREE_V = SW'(AGREE_FIELDS);
  localparam logic [VCNT_W-1:0] LO_525  = VCNT_W'(F525_MIN);
  localparam logic [VCNT_W-1:0] HI_525  = VCNT_W'(F525_MAX);
  localparam logic [VCNT_W-1:0] LO_625  = VCNT_W'(F625_MIN);
  localparam logic [VCNT_W-1:0] HI_625  = VCNT_W'(F625_MAX);

  line_std_e     cls;
  line_std_e     cand;
  logic [SW-1:0] streak;
  logic [SW-1:0] streak_nx;
  logic          seen;

  always_comb begin
    cls = CLS_NONE;
    if (fld_lines >= LO_525 && fld_lines <= HI_525)      cls = CLS_525;
    else if (fld_lines >= LO_625 && fld_lines <= HI_625) cls = CLS_625;
    if (cls == CLS_NONE)                       streak_nx = '0;
    else if (cls == cand && streak != '0)      streak_nx = (streak == AGREE_V) ? streak : streak + 1'b1;
    else                                       streak_nx = SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      cand    <= CLS_NONE;
      streak  <= '0;
      std_625 <= 1'b0;
    end else if (fld_mark) begin
      seen <= 1'b1;
      if (seen) begin
        cand   <= cls;
        streak <= streak_nx;
        if (cls != CLS_NONE && streak_nx == AGREE_V) begin
          std_625 <= (cls == CLS_625);
        end
      end
    end
  end
endmodule

// File: rtl/sync_slave_tracker.sv
module sync_slave_tracker #(
  parameter int HCNT_W       = 12,
  parameter int VCNT_W       = 10,
  parameter int AGREE_FIELDS = 4,
  parameter int F525_MIN     = 262,
  parameter int F525_MAX     = 263,
  parameter int F625_MIN     = 312,
  parameter int F625_MAX     = 313
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic              vsync_n,
  output logic [HCNT_W-1:0] hcount,
  output logic [VCNT_W-1:0] vcount,
  output logic              field2,
  output logic              std_625,
  output logic              locked,
  output logic              vs_misplaced
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0]  sync_in;
  logic [NSYNC-1:0]  sync_fall;
  logic [HCNT_W-1:0] line_len;
  logic              line_ok;
  logic              fld_mark;
  logic [VCNT_W-1:0] fld_lines;

  assign sync_in = {vsync_n, hsync_n};

  for (genvar gi = 0; gi < NSYNC; gi++) begin : g_samp
    sst_sync_sampler u_samp (
      .clk   (clk),
      .rst   (rst),
      .sync_n(sync_in[gi]),
      .fall  (sync_fall[gi])
    );
  end

  sst_line_timer #(.HCNT_W(HCNT_W)) u_line (
    .clk     (clk),
    .rst     (rst),
    .hs_fall (sync_fall[0]),
    .hcount  (hcount),
    .line_len(line_len),
    .line_ok (line_ok),
    .locked  (locked)
  );

  sst_field_tracker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_field (
    .clk      (clk),
    .rst      (rst),
    .hs_fall  (sync_fall[0]),
    .vs_fall  (sync_fall[1]),
    .hcount   (hcount),
    .line_len (line_len),
    .line_ok  (line_ok),
    .vcount   (vcount),
    .field2   (field2),
    .misplaced(vs_misplaced),
    .fld_mark (fld_mark),
    .fld_lines(fld_lines)
  );

  sst_std_detector #(
    .VCNT_W      (VCNT_W),
    .AGREE_FIELDS(AGREE_FIELDS),
    .F525_MIN    (F525_MIN),
    .F525_MAX    (F525_MAX),
    .F625_MIN    (F625_MIN),
    .F625_MAX    (F625_MAX)
  ) u_std (
    .clk      (clk),
    .rst      (rst),
    .fld_mark (fld_mark),
    .fld_lines(fld_lines),
    .std_625  (std_625)
  );
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic [HCNT_W-1:0] hcount,
  input logic [VCNT_W-1:0] vcount,
  input logic              field2,
  input logic              std_625,
  input logic              locked,
  input logic              vs_misplaced
);
  logic [3:1] hs_d;
  logic [4:1] vs_d;
  logic [2:0] age;
  logic       age_ok;
  logic       hs_fell2;
  logic       vs_fell2;
  logic       vs_fell3;

  always_ff @(posedge clk) begin
    hs_d <= {hs_d[2:1], hsync_n};
    vs_d <= {vs_d[3:1], vsync_n};
    if (rst)              age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  assign age_ok   = (age >= 3'd6);
  assign hs_fell2 = age_ok && !hs_d[2] && hs_d[3];
  assign vs_fell2 = age_ok && !vs_d[2] && vs_d[3];
  assign vs_fell3 = age_ok && !vs_d[3] && vs_d[4];

  assert_hcount_restart_R2: assert property (@(posedge clk) disable iff (rst)
    hs_fell2 |-> hcount == HCNT_W'(1));

  assert_hcount_step_R2: assert property (@(posedge clk) disable iff (rst)
    (age_ok && !hs_fell2 && $past(hcount) != '1) |-> hcount == $past(hcount) + 1'b1);

  assert_vcount_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (age_ok && vcount != $past(vcount)) |-> (hs_fell2 || vs_fell2));

  assert_field_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (age_ok && field2 != $past(field2)) |-> vs_fell2);

  assert_misplace_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (age_ok && vs_misplaced) |-> (vs_fell2 && field2 == $past(field2)));

  assert_misplace_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    vs_misplaced |=> !vs_misplaced);

  assert_lock_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (age_ok && locked != $past(locked)) |-> hs_fell2);

  assert_std_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (age_ok && std_625 != $past(std_625)) |-> vs_fell3);
endmodule

bind sync_slave_tracker sst_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) i_sst_checker (
  .clk         (clk),
  .rst         (rst),
  .hsync_n     (hsync_n),
  .vsync_n     (vsync_n),
  .hcount      (hcount),
  .vcount      (vcount),
  .field2      (field2),
  .std_625     (std_625),
  .locked      (locked),
  .vs_misplaced(vs_misplaced)
);

// File: tb/test_sync_slave_tracker.sv
module test_sync_slave_tracker;
  localparam int HW = 12;
  localparam int VW = 10;
  localparam int L  = 32;
  localparam int Q  = L / 4;
  localparam int H  = L / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hsync_n = 1'b1;
  logic          vsync_n = 1'b1;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;
  logic          field2, std_625, locked, vs_misplaced;

  int n_chk = 0;
  int n_bad = 0;
  int mis_seen = 0;
  int vs_hold = 0;
  bit h_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_slave_tracker i_sync_slave_tracker (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hcount(hcount), .vcount(vcount), .field2(field2), .std_625(std_625),
    .locked(locked), .vs_misplaced(vs_misplaced)
  );

  always @(negedge clk) if (vs_misplaced === 1'b1) mis_seen++;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // One line of len clocks; hsync low for 4 clocks at its start,
  // vsync falls at clock index v (none if v < 0) and stays low 6 clocks.
  task automatic gen_line(int len, int v, bit chk_h);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (chk_h) begin
        int e;
        e = (c == 0) ? len - 1 : (c == 1) ? len : c - 1;
        if (int'(hcount) != e) h_err = 1;
      end
      hsync_n = (c < 4) ? 1'b0 : 1'b1;
      if (v == c) vs_hold = 6;
      if (vs_hold > 0) begin
        vsync_n = 1'b0;
        vs_hold--;
      end else begin
        vsync_n = 1'b1;
      end
    end
  endtask

  task automatic frame_part(int total, int first, int last);
    for (int ln = first; ln <= last; ln++) begin
      int v;
      v = (ln == 1) ? 2 : (ln == total / 2 + 1) ? H + 2 : -1;
      gen_line(L, v, 0);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 hcount", int'(hcount), 0);
    check("R1 vcount", int'(vcount), 0);
    check("R1 field2", int'(field2), 0);
    check("R1 std_625", int'(std_625), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 vs_misplaced", int'(vs_misplaced), 0);
    rst = 1'b0;

    // R7: vertical edge before one full line is measured is ignored
    gen_line(L, H, 0);
    gen_line(L, -1, 0);
    check("R7 field2 unchanged", int'(field2), 0);
    check("R7 no misplace flag", mis_seen, 0);

    // R2, R3, R8 on regular lines
    gen_line(L, -1, 1);
    check("R2 hcount sequence errors", int'(h_err), 0);
    check("R3 vcount after three lines", int'(vcount), 3);
    check("R8 locked after equal lines", int'(locked), 1);

    // R4 R5 R6: sweep vertical edge over every position of the line
    begin
      int ef;
      ef = 0;
      for (int v = 0; v < L; v++) begin
        int m0, v0;
        bit st, md;
        m0 = mis_seen;
        v0 = int'(vcount);
        st = (v < Q) || (v > L - Q);
        md = (v > H - Q) && (v < H + Q);
        gen_line(L, v, 0);
        gen_line(L, -1, 0);
        if (st) begin
          ef = 0;
          check($sformatf("R4 field2 at offset %0d", v), int'(field2), ef);
          check($sformatf("R4 vcount at offset %0d", v), int'(vcount), (v < Q) ? 2 : 1);
          check($sformatf("R4 no flag at offset %0d", v), mis_seen - m0, 0);
        end else if (md) begin
          ef = 1;
          check($sformatf("R5 field2 at offset %0d", v), int'(field2), ef);
          check($sformatf("R5 vcount at offset %0d", v), int'(vcount), v0 + 2);
          check($sformatf("R5 no flag at offset %0d", v), mis_seen - m0, 0);
        end else begin
          check($sformatf("R6 field2 kept at offset %0d", v), int'(field2), ef);
          check($sformatf("R6 vcount kept at offset %0d", v), int'(vcount), v0 + 2);
          check($sformatf("R6 one flag at offset %0d", v), mis_seen - m0, 1);
        end
      end
    end

    // R8: an irregular line drops lock until two equal lines follow
    gen_line(40, -1, 0);
    gen_line(L, -1, 0);
    check("R8 lock lost after long line", int'(locked), 0);
    gen_line(L, -1, 0);
    check("R8 still unlocked", int'(locked), 0);
    gen_line(L, -1, 0);
    check("R8 lock regained", int'(locked), 1);

    // R9: 625-line frames
    frame_part(625, 1, 625);
    check("R3 vcount at end of 625 frame", int'(vcount), 625);
    check("R5 field2 in second field", int'(field2), 1);
    frame_part(625, 1, 625);
    check("R9 no switch after three fields", int'(std_625), 0);
    frame_part(625, 1, 1);
    check("R9 switch to 625 after four fields", int'(std_625), 1);
    check("R4 field2 at field 1 start", int'(field2), 0);
    check("R4 vcount at field 1 start", int'(vcount), 1);
    frame_part(625, 2, 625);

    // R9: back to 525 lines
    frame_part(525, 1, 525);
    check("R3 vcount at end of 525 frame", int'(vcount), 525);
    frame_part(525, 1, 525);
    check("R9 hold 625 during 525 agreement", int'(std_625), 1);
    frame_part(525, 1, 1);
    check("R9 switch to 525 after four fields", int'(std_625), 0);

    finish_run();
  end
endmodule